// File: doc/BRIEF.md
# Pattern-Memory Bank Mapper with Fetch-Triggered Latch

This block turns each pattern-table address of a console picture processor (the 0x0000 to 0x1FFF window) into a character ROM bank number counted in 1 KB units. Software programs sixteen byte registers over the CPU write bus. There are eight low bytes and eight high bytes, and each pair forms one 16-bit bank value. Two mode bytes that belong to the wider mapper are fed in as plain inputs. They pick the page size (8K, 4K, 2K or 1K). They also pick whether a 256K outer window is applied: this window masks the bank value and places a 3-bit outer index above it.

In 4K mode each half of pattern space can follow one of two registers. A snoop port watches the processor's own fetches. A fetch of the tile row at offset 0xFD0 or 0xFE0 within a half steers that half to its first or its second register. This lets the bank change in the middle of rendering without any CPU write. A configuration input turns this behaviour on. While it is off, the halves are pinned to registers 0 and 4.

The lookup path (`pat_addr` to `bank_1k`) is combinational. Writes and snooped fetches take effect on the clock edge where they are presented. The snoop port is observe-only: `snoop_valid` has no ready, and the block takes every fetch offered, so it never applies back-pressure.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset every low and high register holds 0xFF. The lower half then follows register 0 and the upper half follows register 4.
- R2: A write with `wr_addr[15:12]`=0x9 stores `wr_data` into low register `wr_addr[2:0]`. A write with `wr_addr[15:12]`=0xA stores it into the high register of that index. Writes to any other address change no register.
- R3: The bank value of register k is {high[k], low[k]}, that is low OR (high shifted left by 8).
- R4: `mode_main[4:3]` selects the page size: 00 is 8K, 01 is 4K, 10 is 2K, 11 is 1K. The output is the combined bank shifted into 1K units by appending `pat_addr[12:10]` in 8K mode, `pat_addr[11:10]` in 4K mode, `pat_addr[10]` in 2K mode, and nothing in 1K mode.
- R5: 8K mode uses register 0. 2K mode uses register 2*`pat_addr[12:11]`. 1K mode uses register `pat_addr[12:10]`. 4K mode uses the latch entry of the half selected by `pat_addr[12]`.
- R6: When `mode_aux[5]` is 0, the outer index is {`mode_aux[4]`, `mode_aux[3]`, `mode_aux[0]`}. The bank value is masked to 0x1F, 0x3F, 0x7F or 0xFF for 8K, 4K, 2K or 1K mode, and the outer index, shifted left by 5, 6, 7 or 8 respectively, is ORed in.
- R7: When `mode_aux[5]` is 1, the full 16-bit bank value is used unmasked and with no outer bits.
- R8: While `latch_en` is 1, a snooped fetch below 0x2000 with bits 11:8 all ones updates one latch entry. Bits 7:4 equal to 0xD set the addressed half (chosen by bit 12) to register 0 (lower half) or register 4 (upper half). Bits 7:4 equal to 0xE set it to register 2 (lower) or register 6 (upper).
- R9: While `latch_en` is 0, snooped fetches are ignored and both latch entries return to registers 0 and 4.
- R10: A snooped fetch at or above 0x2000, or with any other bit pattern, leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| mode_main | input | 8 | Main mode byte; bits 4:3 set the page size |
| mode_aux | input | 8 | Auxiliary mode byte; bits 0, 3, 4 give the outer index, bit 5 bypasses it |
| latch_en | input | 1 | Enables the fetch-triggered latch |
| snoop_valid | input | 1 | A pattern fetch is presented on `snoop_addr` |
| snoop_addr | input | 14 | Address of the snooped fetch |
| pat_addr | input | 14 | Pattern address to translate |
| bank_1k | output | 19 | Bank number in 1 KB units |

## Verification
On every cycle the assertions check the following. Each register update matches the write that caused it. Non-mapper writes leave storage untouched. Latch entries stay within their legal register pairs. A disabled latch falls back to its defaults. The 8K output always carries the pattern address bits below the bank, and outer bits appear where the 1K mode places them. Only the bench scenarios can show the arithmetic of the masks and shifts in each page size, the selection of the correct register per address, and the sequence of latch switches driven by particular fetch rows, because each of these needs a known register content and an expected number.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int BANK_W   = 2 * REG_W;
  localparam int SUB_W    = 3;
  localparam int OUT_W    = BANK_W + SUB_W;
  localparam int OUTER_W  = 3;
  localparam int BASE_SH  = 5;

  typedef enum logic [1:0] {
    PG_8K = 2'b00,
    PG_4K = 2'b01,
    PG_2K = 2'b10,
    PG_1K = 2'b11
  } page_e;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/chr_reg_file.sv
module chr_reg_file
  import chr_map_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [15:0]                   wr_addr,
  input  logic [REG_W-1:0]              wr_data,
  output logic [NUM_REGS-1:0][BANK_W-1:0] bank_vals
);
  localparam logic [3:0] LO_REGION = 4'h9;
  localparam logic [3:0] HI_REGION = 4'hA;

  logic hit_lo, hit_hi;
  assign hit_lo = wr_en && (wr_addr[15:12] == LO_REGION);
  assign hit_hi = wr_en && (wr_addr[15:12] == HI_REGION);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [REG_W-1:0] lo_q, hi_q;
    logic sel;
    assign sel = (wr_addr[IDX_W-1:0] == idx_t'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '1;
        hi_q <= '1;
      end else begin
        if (hit_lo && sel) lo_q <= wr_data;
        if (hit_hi && sel) hi_q <= wr_data;
      end
    end

    assign bank_vals[k] = {hi_q, lo_q};

    a_r2_low_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:12] == 4'h9 && wr_addr[IDX_W-1:0] == idx_t'(k))
      |=> bank_vals[k][REG_W-1:0] == $past(wr_data));
    a_r2_high_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:12] == 4'hA && wr_addr[IDX_W-1:0] == idx_t'(k))
      |=> bank_vals[k][BANK_W-1:REG_W] == $past(wr_data));
  end

  a_r2_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (wr_addr[15:12] != 4'h9 && wr_addr[15:12] != 4'hA))
    |=> $stable(bank_vals));
endmodule

// File: rtl/chr_fetch_latch.sv
module chr_fetch_latch
  import chr_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        latch_en,
  input  logic        snoop_valid,
  input  logic [13:0] snoop_addr,
  output idx_t        sel_lo,
  output idx_t        sel_hi
);
  localparam idx_t LO_FIRST  = idx_t'(0);
  localparam idx_t LO_SECOND = idx_t'(2);
  localparam idx_t HI_FIRST  = idx_t'(4);
  localparam idx_t HI_SECOND = idx_t'(6);

  logic in_pattern, row_ff, trig_d, trig_e, upper;
  assign in_pattern = (snoop_addr[13] == 1'b0);
  assign row_ff     = (snoop_addr[11:8] == 4'hF);
  assign trig_d     = snoop_valid && in_pattern && row_ff && (snoop_addr[7:4] == 4'hD);
  assign trig_e     = snoop_valid && in_pattern && row_ff && (snoop_addr[7:4] == 4'hE);
  assign upper      = snoop_addr[12];

  always_ff @(posedge clk) begin
    if (!rst_n || !latch_en) begin
      sel_lo <= LO_FIRST;
      sel_hi <= HI_FIRST;
    end else if (trig_d || trig_e) begin
      if (upper) sel_hi <= trig_e ? HI_SECOND : HI_FIRST;
      else       sel_lo <= trig_e ? LO_SECOND : LO_FIRST;
    end
  end

  a_r8_lo_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lo == LO_FIRST) || (sel_lo == LO_SECOND));
  a_r8_hi_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi == HI_FIRST) || (sel_hi == HI_SECOND));
  a_r9_disabled_default: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> (sel_lo == LO_FIRST) && (sel_hi == HI_FIRST));
  a_r10_high_fetch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && snoop_valid && snoop_addr[13]) |=> $stable(sel_lo) && $stable(sel_hi));
endmodule

// File: rtl/chr_bank_calc.sv
module chr_bank_calc
  import chr_map_pkg::*;
(
  input  logic [NUM_REGS-1:0][BANK_W-1:0] bank_vals,
  input  logic [1:0]                      page_mode,
  input  logic                            outer_bypass,
  input  logic [OUTER_W-1:0]              outer_idx,
  input  idx_t                            sel_lo,
  input  idx_t                            sel_hi,
  input  logic [2:0]                      sub_addr,
  output logic [OUT_W-1:0]                bank_1k
);
  idx_t  reg_idx;
  bank_t raw, mask, outer_sh, combined;
  int unsigned sh;

  always_comb begin
    unique case (page_e'(page_mode))
      PG_8K: reg_idx = idx_t'(0);
      PG_4K: reg_idx = sub_addr[2] ? sel_hi : sel_lo;
      PG_2K: reg_idx = {sub_addr[2:1], 1'b0};
      default: reg_idx = sub_addr;
    endcase
  end

  assign raw = bank_vals[reg_idx];

  always_comb begin
    sh       = BASE_SH + int'(page_mode);
    mask     = bank_t'((32'd1 << sh) - 32'd1);
    outer_sh = bank_t'(outer_idx) << sh;
    combined = outer_bypass ? raw : ((raw & mask) | outer_sh);
  end

  always_comb begin
    unique case (page_e'(page_mode))
      PG_8K: bank_1k = {combined, sub_addr};
      PG_4K: bank_1k = {1'b0, combined, sub_addr[1:0]};
      PG_2K: bank_1k = {2'b00, combined, sub_addr[0]};
      default: bank_1k = {3'b000, combined};
    endcase
  end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        mode_main,
  input  logic [7:0]        mode_aux,
  input  logic              latch_en,
  input  logic              snoop_valid,
  input  logic [13:0]       snoop_addr,
  input  logic [13:0]       pat_addr,
  output logic [OUT_W-1:0]  bank_1k
);
  logic [NUM_REGS-1:0][BANK_W-1:0] bank_vals;
  idx_t sel_lo, sel_hi;
  logic [OUTER_W-1:0] outer_idx;

  assign outer_idx = {mode_aux[4], mode_aux[3], mode_aux[0]};

  chr_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank_vals(bank_vals)
  );

  chr_fetch_latch u_latch (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .sel_lo(sel_lo), .sel_hi(sel_hi)
  );

  chr_bank_calc u_calc (
    .bank_vals(bank_vals), .page_mode(mode_main[4:3]), .outer_bypass(mode_aux[5]),
    .outer_idx(outer_idx), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .sub_addr(pat_addr[12:10]), .bank_1k(bank_1k)
  );

  a_r4_8k_suffix: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_main[4:3] == 2'b00) |-> (bank_1k[2:0] == pat_addr[12:10]));
  a_r6_outer_1k: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_main[4:3] == 2'b11 && !mode_aux[5]) |-> (bank_1k[10:8] == outer_idx));
  a_r7_bypass_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_main[4:3] == 2'b11) |-> (bank_1k[OUT_W-1:BANK_W] == '0));
endmodule

// File: tb/sim_chr_bank_mapper.sv
`timescale 1ns/1ps
module sim_chr_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  mode_main = '0;
  logic [7:0]  mode_aux = 8'h20;
  logic        latch_en = 1'b0;
  logic        snoop_valid = 1'b0;
  logic [13:0] snoop_addr = '0;
  logic [13:0] pat_addr = '0;
  logic [18:0] bank_1k;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chr_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_main(mode_main), .mode_aux(mode_aux), .latch_en(latch_en),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .pat_addr(pat_addr),
    .bank_1k(bank_1k)
  );

  // mode_main, mode_aux, pat_addr, expected; registers hold {k, 0x10+k}
  localparam int NV = 14;
  localparam logic [7:0]  VM [NV] = '{8'h18,8'h18,8'h10,8'h10,8'h10,8'h00,8'h08,8'h08,
                                      8'h18,8'h00,8'h10,8'h08,8'h18,8'h18};
  localparam logic [7:0]  VA [NV] = '{8'h20,8'h20,8'h20,8'h20,8'h20,8'h20,8'h20,8'h20,
                                      8'h19,8'h19,8'h19,8'h01,8'h08,8'h19};
  localparam logic [13:0] VP [NV] = '{14'h0C00,14'h1C00,14'h0800,14'h0C00,14'h1400,14'h1C00,
                                      14'h1400,14'h0800,14'h0C00,14'h0000,14'h1800,14'h1000,
                                      14'h0400,14'h1C00};
  localparam logic [18:0] VE [NV] = '{19'h00313,19'h00717,19'h00424,19'h00425,19'h00829,19'h00087,
                                      19'h01051,19'h00042,19'h00713,19'h00780,19'h0072C,19'h00150,
                                      19'h00211,19'h00717};

  task automatic check(input string req, input logic [18:0] exp);
    checks++;
    if (bank_1k !== exp) begin
      errors++;
      $display("FAIL %s: bank_1k=%h expected=%h", req, bank_1k, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic fetch(input logic [13:0] a);
    @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk); snoop_valid = 1'b0;
  endtask

  task automatic look(input logic [7:0] m, input logic [7:0] x, input logic [13:0] p);
    mode_main = m; mode_aux = x; pat_addr = p; #1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    look(8'h18, 8'h20, 14'h0000); check("R1 reset 1K", 19'h0FFFF);
    look(8'h00, 8'h20, 14'h0000); check("R1 reset 8K", 19'h7FFF8);
    look(8'h08, 8'h20, 14'h1000); check("R1 reset 4K upper", 19'h3FFFC);

    for (int k = 0; k < 8; k++) begin
      wr(16'h9000 | 16'(k) | 16'h0FF0, 8'h10 + 8'(k));
      wr(16'hA000 | 16'(k), 8'(k));
    end

    // R3 R4 R5 R6 R7 table
    for (int i = 0; i < NV; i++) begin
      look(VM[i], VA[i], VP[i]);
      check($sformatf("R3/R4/R5/R6/R7 vec%0d", i), VE[i]);
    end

    // R2 other regions ignored
    wr(16'hB003, 8'h00); wr(16'h8003, 8'h00); wr(16'hC003, 8'h00);
    look(8'h18, 8'h20, 14'h0C00); check("R2 ignored regions", 19'h00313);
    wr(16'h9FF3, 8'h55);
    look(8'h18, 8'h20, 14'h0C00); check("R2 low write", 19'h00355);
    wr(16'hA003, 8'h03);
    wr(16'h9003, 8'h13);

    // R8 latch
    latch_en = 1'b1;
    fetch(14'h0FE0);
    look(8'h08, 8'h20, 14'h0000); check("R8 lower to reg2", 19'h00848);
    fetch(14'h1FE0);
    look(8'h08, 8'h20, 14'h1000); check("R8 upper to reg6", 19'h01858);
    look(8'h08, 8'h20, 14'h0400); check("R8 lower kept", 19'h00849);
    // R10 ignored fetches
    fetch(14'h2FD0); fetch(14'h0ED0); fetch(14'h0FC0);
    look(8'h08, 8'h20, 14'h0000); check("R10 ignored fetches", 19'h00848);
    fetch(14'h0FD0);
    look(8'h08, 8'h20, 14'h0000); check("R8 lower back to reg0", 19'h00040);
    fetch(14'h1FD0);
    look(8'h08, 8'h20, 14'h1000); check("R8 upper back to reg4", 19'h01050);
    fetch(14'h1FE0); fetch(14'h0FE0);
    // R9 disable restores defaults
    @(negedge clk); latch_en = 1'b0;
    @(negedge clk);
    look(8'h08, 8'h20, 14'h1000); check("R9 upper default", 19'h01050);
    look(8'h08, 8'h20, 14'h0000); check("R9 lower default", 19'h00040);
    fetch(14'h1FE0);
    look(8'h08, 8'h20, 14'h1000); check("R9 fetch ignored while off", 19'h01050);
    @(negedge clk); latch_en = 1'b1;
    @(negedge clk);
    look(8'h08, 8'h20, 14'h1000); check("R9 re-enable starts default", 19'h01050);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule